// File: doc/BRIEF.md
# Virtual Interrupt List Prioritizer

This block holds a small, parameterized set of virtual interrupt slots that a hypervisor fills through a single write port. Each slot carries a virtual ID, a group bit, an 8-bit priority, a two-bit lifecycle state and an optional link to a physical interrupt ID. Every cycle the block picks the pending slot with the numerically lowest priority among the groups the guest has enabled. It raises that slot on the fast line or on the normal line, but only when the slot's priority passes both the priority mask and the running priority.

The guest side sends three kinds of request: acknowledge, end-of-interrupt and deactivate. An acknowledge returns the chosen virtual ID and marks that slot active. EOI and deactivate find the slot by virtual ID among active slots and retire it. The EOI mode input selects whether an EOI retires the slot itself or leaves that to a separate deactivate request. When a retired slot is linked to hardware, the block sends a one-cycle pulse carrying the physical ID. A request that finds no matching slot produces a miss pulse. Active-priority bookkeeping, maintenance signalling and spilling of slots to memory are handled outside the block. The running priority arrives as an input.

Top module: `vlist_prio`

## Requirements
- R1: After reset every slot is inactive. `vfiq`, `virq`, `ack_vld`, `pdeact_vld` and `eoi_miss` are low.
- R2: A cycle with `wr_en` high loads the slot at `wr_idx` with all its fields at the clock edge. The state encoding is 0 inactive, 1 pending, 2 active, 3 active-and-pending.
- R3: The candidate is the slot in state pending whose group is enabled and whose priority value is lowest. `grp_en[0]` enables group 0 and `grp_en[1]` enables group 1. Among equal priorities the lowest slot index wins.
- R4: The candidate is signalled only if its priority is strictly below `pri_mask` and its group priority is strictly below `run_pri`. The group priority is the priority with its low `bin_pt`+1 bits cleared.
- R5: A signalled group 0 candidate drives `vfiq`. A signalled group 1 candidate drives `virq`. The two lines are never high together.
- R6: `ack_req` makes `ack_vld` high one cycle later, with `ack_vid` equal to the signalled slot's virtual ID. That slot becomes active at the same edge.
- R7: An acknowledge while nothing is signalled returns `ack_vid` = 1023 and changes no slot.
- R8: Deactivating a slot moves it from active to inactive, or from active-and-pending to pending.
- R9: When a deactivated slot is hardware-linked, `pdeact_vld` pulses one cycle later, with `pdeact_pid` equal to that slot's physical ID. Unlinked slots give no pulse.
- R10: With `eoi_mode` = 0 an EOI deactivates and a deactivate request is ignored. With `eoi_mode` = 1 an EOI changes no slot and a deactivate request deactivates.
- R11: EOI and deactivate match their virtual ID only against slots that are active or active-and-pending. `eoi_miss` pulses one cycle later for an EOI with no match in either mode, and for a deactivate with no match in mode 1.
- R12: A write to a slot in the same cycle as an acknowledge or deactivate of that slot takes precedence. The slot holds the written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot index to write |
| wr_vid | input | VID_W | Virtual ID to store |
| wr_grp | input | 1 | Group bit to store |
| wr_state | input | 2 | Lifecycle state to store |
| wr_pri | input | PRI_W | Priority to store |
| wr_hw | input | 1 | Hardware-link bit to store |
| wr_pid | input | PID_W | Physical ID to store |
| grp_en | input | 2 | Per-group enables (bit 0 group 0) |
| pri_mask | input | PRI_W | Priority mask |
| run_pri | input | PRI_W | Running priority |
| bin_pt | input | 3 | Binary point for group priority |
| eoi_mode | input | 1 | 0 combined EOI, 1 split EOI |
| ack_req | input | 1 | Acknowledge request |
| eoi_req | input | 1 | End-of-interrupt request |
| eoi_vid | input | VID_W | Virtual ID of the EOI |
| dir_req | input | 1 | Deactivate request |
| dir_vid | input | VID_W | Virtual ID to deactivate |
| vfiq | output | 1 | Fast interrupt line (group 0) |
| virq | output | 1 | Normal interrupt line (group 1) |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_vid | output | VID_W | Acknowledged virtual ID, or 1023 |
| pdeact_vld | output | 1 | Physical deactivate pulse |
| pdeact_pid | output | PID_W | Physical ID being deactivated |
| eoi_miss | output | 1 | Unmatched EOI or deactivate pulse |

## Verification
The bench builds the block with its default parameters: four slots, 16-bit virtual IDs, 13-bit physical IDs and 8-bit priorities. Four slots are enough to set up ties between equal priorities at different indices, a mix of groups, and slots in every lifecycle state in one scenario. The 8-bit priority with a 3-bit binary point lets the tests reach cases where the group priority passes `run_pri` while the full priority would not. The 16-bit ID width also holds the value 1023 returned when nothing is signalled.

// File: rtl/vlist_pkg.sv
package vlist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PEND    = 2'd1,
    ST_ACT     = 2'd2,
    ST_ACTPEND = 2'd3
  } vl_state_e;

  localparam int SPURIOUS_ID = 1023;

endpackage

// File: rtl/vlist_store.sv
module vlist_store
  import vlist_pkg::*;
#(
  parameter int N     = 4,
  parameter int VID_W = 16,
  parameter int PID_W = 13,
  parameter int PRI_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [VID_W-1:0]            wr_vid,
  input  logic                        wr_grp,
  input  logic [1:0]                  wr_state,
  input  logic [PRI_W-1:0]            wr_pri,
  input  logic                        wr_hw,
  input  logic [PID_W-1:0]            wr_pid,
  input  logic [N-1:0]                ack_hit,
  input  logic [N-1:0]                deact_hit,
  output logic [N-1:0][1:0]           st_q,
  output logic [N-1:0][VID_W-1:0]     vid_q,
  output logic [N-1:0]                grp_q,
  output logic [N-1:0][PRI_W-1:0]     pri_q,
  output logic [N-1:0]                hw_q,
  output logic [N-1:0][PID_W-1:0]     pid_q
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic       wr_hit;
    logic [1:0] st_d;

    assign wr_hit = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      st_d = st_q[i];
      if (wr_hit) begin
        st_d = wr_state;
      end else if (ack_hit[i]) begin
        st_d = ST_ACT;
      end else if (deact_hit[i]) begin
        st_d = (st_q[i] == ST_ACTPEND) ? ST_PEND : ST_IDLE;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= ST_IDLE;
      end else begin
        st_q[i] <= st_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_hit) begin
        vid_q[i] <= wr_vid;
        grp_q[i] <= wr_grp;
        pri_q[i] <= wr_pri;
        hw_q[i]  <= wr_hw;
        pid_q[i] <= wr_pid;
      end
    end

    // R6
    ack_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[i] && !wr_hit) |=> (st_q[i] == ST_ACT));

    // R8
    deact_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deact_hit[i] && !wr_hit) |=>
        (st_q[i] == (($past(st_q[i]) == ST_ACTPEND) ? ST_PEND : ST_IDLE)));
  end

endmodule

// File: rtl/vlist_pick.sv
module vlist_pick
  import vlist_pkg::*;
#(
  parameter int N     = 4,
  parameter int PRI_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0][1:0]       st_q,
  input  logic [N-1:0]            grp_q,
  input  logic [N-1:0][PRI_W-1:0] pri_q,
  input  logic [1:0]              grp_en,
  output logic                    sel_valid,
  output logic [IDX_W-1:0]        sel_idx,
  output logic [PRI_W-1:0]        sel_pri
);

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_pri   = '1;
    for (int i = 0; i < N; i++) begin
      if (st_q[i] == ST_PEND && grp_en[grp_q[i]] &&
          (!sel_valid || pri_q[i] < sel_pri)) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        sel_pri   = pri_q[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3
    no_better_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] == ST_PEND && grp_en[grp_q[i]]) |-> (sel_valid && pri_q[i] >= sel_pri));
  end

endmodule

// File: rtl/vlist_match.sv
module vlist_match
  import vlist_pkg::*;
#(
  parameter int N     = 4,
  parameter int VID_W = 16
) (
  input  logic [N-1:0][1:0]       st_q,
  input  logic [N-1:0][VID_W-1:0] vid_q,
  input  logic [VID_W-1:0]        key,
  output logic [N-1:0]            hit,
  output logic                    found
);

  logic [N-1:0] raw;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign raw[i] = (st_q[i] == ST_ACT || st_q[i] == ST_ACTPEND) && (vid_q[i] == key);
  end

  always_comb begin
    hit   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (raw[i] && !found) begin
        hit[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vlist_prio.sv
module vlist_prio
  import vlist_pkg::*;
#(
  parameter int N     = 4,
  parameter int VID_W = 16,
  parameter int PID_W = 13,
  parameter int PRI_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int BP_W  = $clog2(PRI_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VID_W-1:0]  wr_vid,
  input  logic              wr_grp,
  input  logic [1:0]        wr_state,
  input  logic [PRI_W-1:0]  wr_pri,
  input  logic              wr_hw,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [1:0]        grp_en,
  input  logic [PRI_W-1:0]  pri_mask,
  input  logic [PRI_W-1:0]  run_pri,
  input  logic [BP_W-1:0]   bin_pt,
  input  logic              eoi_mode,
  input  logic              ack_req,
  input  logic              eoi_req,
  input  logic [VID_W-1:0]  eoi_vid,
  input  logic              dir_req,
  input  logic [VID_W-1:0]  dir_vid,
  output logic              vfiq,
  output logic              virq,
  output logic              ack_vld,
  output logic [VID_W-1:0]  ack_vid,
  output logic              pdeact_vld,
  output logic [PID_W-1:0]  pdeact_pid,
  output logic              eoi_miss
);

  logic [N-1:0][1:0]       st_q;
  logic [N-1:0][VID_W-1:0] vid_q;
  logic [N-1:0]            grp_q;
  logic [N-1:0][PRI_W-1:0] pri_q;
  logic [N-1:0]            hw_q;
  logic [N-1:0][PID_W-1:0] pid_q;

  logic              sel_valid;
  logic [IDX_W-1:0]  sel_idx;
  logic [PRI_W-1:0]  sel_pri;
  logic [PRI_W-1:0]  gmask;
  logic              sig;
  logic [N-1:0]      ack_hit;
  logic [N-1:0]      deact_hit;
  logic [N-1:0]      e_hit;
  logic [N-1:0]      d_hit;
  logic              e_found;
  logic              d_found;
  logic              miss_d;
  logic              pdeact_d;
  logic [PID_W-1:0]  pid_d;
  logic [VID_W-1:0]  ack_vid_d;

  vlist_store #(.N(N), .VID_W(VID_W), .PID_W(PID_W), .PRI_W(PRI_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vid(wr_vid), .wr_grp(wr_grp),
    .wr_state(wr_state), .wr_pri(wr_pri), .wr_hw(wr_hw), .wr_pid(wr_pid),
    .ack_hit(ack_hit), .deact_hit(deact_hit),
    .st_q(st_q), .vid_q(vid_q), .grp_q(grp_q), .pri_q(pri_q),
    .hw_q(hw_q), .pid_q(pid_q)
  );

  vlist_pick #(.N(N), .PRI_W(PRI_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .st_q(st_q), .grp_q(grp_q), .pri_q(pri_q), .grp_en(grp_en),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_pri(sel_pri)
  );

  vlist_match #(.N(N), .VID_W(VID_W)) u_match_eoi (
    .st_q(st_q), .vid_q(vid_q), .key(eoi_vid), .hit(e_hit), .found(e_found)
  );

  vlist_match #(.N(N), .VID_W(VID_W)) u_match_dir (
    .st_q(st_q), .vid_q(vid_q), .key(dir_vid), .hit(d_hit), .found(d_found)
  );

  // Signalling gate: mask and running-priority comparison
  assign gmask = {PRI_W{1'b1}} << ({1'b0, bin_pt} + (BP_W+1)'(1));
  assign sig   = sel_valid && (sel_pri < pri_mask) && ((sel_pri & gmask) < run_pri);
  assign vfiq  = sig && !grp_q[sel_idx];
  assign virq  = sig &&  grp_q[sel_idx];

  always_comb begin
    ack_hit = '0;
    if (ack_req && sig) begin
      ack_hit[sel_idx] = 1'b1;
    end
  end

  assign ack_vid_d = sig ? vid_q[sel_idx] : VID_W'(SPURIOUS_ID);

  always_comb begin
    deact_hit = '0;
    if (eoi_req && !eoi_mode) begin
      deact_hit = e_hit;
    end else if (dir_req && eoi_mode) begin
      deact_hit = d_hit;
    end
  end

  assign miss_d   = (eoi_req && !e_found) || (dir_req && eoi_mode && !d_found);
  assign pdeact_d = |(deact_hit & hw_q);

  always_comb begin
    pid_d = '0;
    for (int i = 0; i < N; i++) begin
      if (deact_hit[i]) begin
        pid_d = pid_d | pid_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld    <= 1'b0;
      pdeact_vld <= 1'b0;
      eoi_miss   <= 1'b0;
    end else begin
      ack_vld    <= ack_req;
      pdeact_vld <= pdeact_d;
      eoi_miss   <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vid    <= '0;
      pdeact_pid <= '0;
    end else begin
      if (ack_req) begin
        ack_vid <= ack_vid_d;
      end
      if (pdeact_d) begin
        pdeact_pid <= pid_d;
      end
    end
  end

  // R5
  lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vfiq, virq}));

  // R6
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(ack_req));

  // R9
  pdeact_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdeact_vld |-> $past(eoi_req || dir_req));

  // R11
  miss_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_miss |-> $past(eoi_req || dir_req));

endmodule

// File: tb/vlist_prio_test.sv
module vlist_prio_test;

  localparam int N = 4, VID_W = 16, PID_W = 13, PRI_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0; logic [1:0] wr_idx = 0; logic [VID_W-1:0] wr_vid = 0;
  logic wr_grp = 0; logic [1:0] wr_state = 0; logic [PRI_W-1:0] wr_pri = 0;
  logic wr_hw = 0; logic [PID_W-1:0] wr_pid = 0;
  logic [1:0] grp_en = 2'b11; logic [7:0] pri_mask = 8'hFF, run_pri = 8'hFF;
  logic [2:0] bin_pt = 0; logic eoi_mode = 0;
  logic ack_req = 0, eoi_req = 0, dir_req = 0;
  logic [VID_W-1:0] eoi_vid = 0, dir_vid = 0;
  logic vfiq, virq, ack_vld, pdeact_vld, eoi_miss;
  logic [VID_W-1:0] ack_vid;
  logic [PID_W-1:0] pdeact_pid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vlist_prio #(.N(N), .VID_W(VID_W), .PID_W(PID_W), .PRI_W(PRI_W)) uut (.*);

  typedef struct packed {
    logic [31:0] pri;  // slot3..slot0
    logic [7:0]  st;
    logic [3:0]  grp;
    logic [7:0]  mask;
    logic [7:0]  run;
    logic [2:0]  bp;
    logic [1:0]  en;
    logic        fiq;
    logic        irq;
    logic [15:0] vid;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h3C141428, 8'b01010101, 4'b1010, 8'hFF, 8'hFF, 3'd0, 2'b11, 1'b0, 1'b1, 16'd101},
    '{32'h3C141428, 8'b01010101, 4'b1010, 8'hFF, 8'hFF, 3'd0, 2'b01, 1'b1, 1'b0, 16'd102},
    '{32'h3C141428, 8'b01010101, 4'b1010, 8'd20, 8'hFF, 3'd0, 2'b11, 1'b0, 1'b0, 16'd1023},
    '{32'h3C141428, 8'b01010101, 4'b1010, 8'hFF, 8'd16, 3'd0, 2'b11, 1'b0, 1'b0, 16'd1023},
    '{32'h3C141428, 8'b01010101, 4'b1010, 8'hFF, 8'd21, 3'd0, 2'b11, 1'b0, 1'b1, 16'd101},
    '{32'h3C141428, 8'b01010101, 4'b1010, 8'hFF, 8'd17, 3'd3, 2'b11, 1'b0, 1'b1, 16'd101},
    '{32'h3C141428, 8'b01111001, 4'b1010, 8'hFF, 8'hFF, 3'd0, 2'b11, 1'b1, 1'b0, 16'd100},
    '{32'h3C141428, 8'b00000000, 4'b1010, 8'hFF, 8'hFF, 3'd0, 2'b11, 1'b0, 1'b0, 16'd1023}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int vid, input bit grp, input int st,
                    input int pri, input bit hw, input int pid);
    wr_en = 1; wr_idx = 2'(idx); wr_vid = VID_W'(vid); wr_grp = grp;
    wr_state = 2'(st); wr_pri = 8'(pri); wr_hw = hw; wr_pid = PID_W'(pid);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_ack(output int vid, output bit vld);
    ack_req = 1;
    @(negedge clk);
    vid = int'(ack_vid); vld = ack_vld;
    ack_req = 0;
  endtask

  task automatic do_eoi(input int vid);
    eoi_req = 1; eoi_vid = VID_W'(vid);
    @(negedge clk);
    eoi_req = 0;
  endtask

  task automatic do_dir(input int vid);
    dir_req = 1; dir_vid = VID_W'(vid);
    @(negedge clk);
    dir_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v; bit vl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 vfiq", vfiq, 0);
    chk("R1 virq", virq, 0);
    chk("R1 pulses", {ack_vld, pdeact_vld, eoi_miss}, 0);
    do_ack(v, vl);
    chk("R7 ack after reset", v, 1023);

    // Table of selection scenarios: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 4; s++) begin
        wr(s, 100 + s, VECS[k].grp[s], int'(VECS[k].st[2*s +: 2]),
           int'(VECS[k].pri[8*s +: 8]), 0, 0);
      end
      pri_mask = VECS[k].mask; run_pri = VECS[k].run;
      bin_pt = VECS[k].bp; grp_en = VECS[k].en;
      @(negedge clk);
      chk($sformatf("R3/R4/R5 vec%0d vfiq", k), vfiq, VECS[k].fiq);
      chk($sformatf("R3/R4/R5 vec%0d virq", k), virq, VECS[k].irq);
      do_ack(v, vl);
      chk($sformatf("R2/R6/R7 vec%0d ack_vid", k), v, VECS[k].vid);
    end

    pri_mask = 8'hFF; run_pri = 8'hFF; bin_pt = 0; grp_en = 2'b11; eoi_mode = 0;
    for (int s = 0; s < 4; s++) wr(s, 0, 0, 0, 0, 0, 0);

    // Combined mode, linked slot
    wr(0, 200, 1, 1, 10, 1, 77);
    chk("R5 group1 drives virq", virq, 1);
    do_ack(v, vl);
    chk("R6 ack_vld", vl, 1);
    chk("R6 ack_vid", v, 200);
    chk("R6 slot active, line drops", virq, 0);
    do_eoi(200);
    chk("R9 R10 pdeact on combined eoi", pdeact_vld, 1);
    chk("R9 pdeact pid", pdeact_pid, 77);
    chk("R11 no miss on match", eoi_miss, 0);
    do_eoi(200);
    chk("R8 slot inactive so eoi misses", eoi_miss, 1);
    chk("R9 no pdeact on miss", pdeact_vld, 0);

    // Active-and-pending, unlinked, combined mode
    wr(0, 200, 0, 3, 10, 0, 0);
    chk("R3 active-pending not signalled", vfiq, 0);
    do_dir(200);
    chk("R10 dir ignored in mode 0", {pdeact_vld, eoi_miss, vfiq}, 0);
    do_eoi(200);
    chk("R9 no pdeact for unlinked", pdeact_vld, 0);
    chk("R8 active-pending back to pending", vfiq, 1);

    // Split mode
    eoi_mode = 1;
    wr(0, 200, 1, 2, 10, 1, 55);
    do_eoi(200);
    chk("R10 eoi in mode 1 no deactivate", {pdeact_vld, eoi_miss}, 0);
    do_dir(200);
    chk("R10 dir deactivates in mode 1", pdeact_vld, 1);
    chk("R9 pdeact pid split", pdeact_pid, 55);
    do_dir(200);
    chk("R11 dir miss in mode 1", eoi_miss, 1);
    eoi_mode = 0;
    do_eoi(999);
    chk("R11 unmatched eoi", eoi_miss, 1);

    // R12 write beats acknowledge on same slot
    wr(0, 300, 1, 1, 5, 0, 0);
    ack_req = 1;
    wr_en = 1; wr_idx = 0; wr_vid = 301; wr_grp = 1; wr_state = 1; wr_pri = 5; wr_hw = 0;
    @(negedge clk);
    ack_req = 0; wr_en = 0;
    chk("R12 ack returns old id", int'(ack_vid), 300);
    chk("R12 written slot still pending", virq, 1);
    do_ack(v, vl);
    chk("R12 written id acknowledged", v, 301);

    finish_run();
  end

endmodule